// File: doc/BRIEF.md
# Command-Driven Byte Peripheral Port

This block attaches one byte-wide peripheral to a simple CPU register bus. The CPU reaches three registers through the low address bits: a data register, a status register and a command register. Only accesses whose upper address bits match the block's base address count, and only while the I/O-space select is high. A two-bit opcode written to the command register starts one of four actions:

- enable or disable the peripheral and clear faults;
- query status;
- pull one byte from the peripheral;
- push the data register out to the peripheral.

Each action ends by raising an interrupt request. The CPU withdraws the request with an acknowledge pulse.

Both peripheral directions are valid/ready byte streams that carry an even-parity bit. A transfer happens on a clock edge where valid and ready are both high. On the receive side the block drives ready, and only while a read command is waiting for its byte. On the transmit side the block holds valid, data and parity steady until the peripheral raises ready. The peripheral may stall for any number of cycles. A received byte sets a data-available flag. The CPU's read of the data register clears that flag and frees the block, so each byte is taken exactly once.

Top module: `pio_port`

## Requirements
- R1: An access counts only when cpu_addr[7:2] equals the base (default 8'h40 >> 2) and cpu_addr[1:0] selects 0 = data, 1 = status or 2 = command. Offset 3 and any non-matching address read as zero and change nothing.
- R2: With cpu_sel low, every read returns zero and every write has no effect, even at a matching address.
- R3: The status register holds: bit0 busy, bit1 ready (not busy), bit2 data available, bit3 error, bit4 peripheral enabled, bit5 interrupt pending. Bits 7:6 read zero.
- R4: After synchronous reset the status reads 8'h02, irq is low, dev_en is low, rx_ready is low and tx_valid is low.
- R5: Command bits [1:0]: 00 control, 01 test, 10 read, 11 write. Control copies command bit 2 to dev_en and clears the error flag. Control and test complete in one cycle, do not set busy, and raise irq.
- R6: A read command sets busy and raises rx_ready. The byte accepted on the handshake edge is stored in the data register, sets data available and raises irq, and rx_ready falls. Busy stays set until the CPU reads the data register.
- R7: Reading the data register clears data available and busy. A second read of the data register without a new byte leaves data available clear.
- R8: Received parity is even: rx_par must equal the XOR of rx_data. A mismatch sets the error flag, the byte is still stored, and the flag stays set until the next control command.
- R9: A write command while not busy sets busy and presents the data register on tx_data, with tx_par equal to the XOR of the data bits. tx_valid, tx_data and tx_par stay stable while tx_ready is low. On the accepting edge busy clears and irq rises.
- R10: While busy, a read or write command is ignored and sets the error flag, and a write to the data register is ignored.
- R11: irq stays high until an irq_ack cycle, which clears it unless a new completion occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | I/O-space select qualifying every access |
| cpu_addr | input | 8 | CPU address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of cpu_rd |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| dev_en | output | 1 | Peripheral enable |
| rx_valid | input | 1 | Peripheral byte valid |
| rx_ready | output | 1 | Block ready to take a peripheral byte |
| rx_data | input | 8 | Peripheral byte |
| rx_par | input | 1 | Parity bit of rx_data |
| tx_valid | output | 1 | Byte to peripheral valid |
| tx_ready | input | 1 | Peripheral accepts the byte |
| tx_data | output | 8 | Byte to peripheral |
| tx_par | output | 1 | Even parity bit of tx_data |

## Verification
A sequencer stuck in a busy state shows as a status byte with bit0 set on the next status read. It also shows as a missing irq edge, or as a handshake line (rx_ready or tx_valid) still high one cycle after its transfer. A data-available flag that fails to clear is visible on the status read right after the data read. Decode or select faults appear on the same cycle as the stray access, as non-zero read data or a changed status. Transmit corruption under stall is caught on the first stalled cycle by the peripheral-side scoreboard.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_TEST  = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RX_WAIT,
    S_RX_HOLD,
    S_TX_WAIT
  } seq_st_e;

  localparam int OFS_W    = 2;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;

  localparam int ST_BUSY  = 0;
  localparam int ST_READY = 1;
  localparam int ST_AVAIL = 2;
  localparam int ST_ERR   = 3;
  localparam int ST_EN    = 4;
  localparam int ST_IRQ   = 5;
  localparam int ST_BITS  = 6;

  localparam int CTRL_EN_BIT = 2;
endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
  import pio_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              data_wr,
  output logic              data_rd,
  output logic              stat_rd,
  output logic              cmd_wr
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic base_hit;
  logic [3:0] ofs_hit;

  assign base_hit = sel && (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);

  for (genvar g = 0; g < 4; g++) begin : g_ofs
    assign ofs_hit[g] = base_hit && (addr[OFS_W-1:0] == OFS_W'(g));
  end

  assign data_wr = wr && ofs_hit[OFS_DATA];
  assign data_rd = rd && ofs_hit[OFS_DATA];
  assign stat_rd = rd && ofs_hit[OFS_STAT];
  assign cmd_wr  = wr && ofs_hit[OFS_CMD];

  logic unused_hi;
  assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b0;
endmodule

// File: rtl/pio_link.sv
module pio_link #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_par,
  output logic              rx_fire,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_perr,
  output logic              tx_fire
);
  assign rx_ready = rx_en;
  assign rx_fire  = rx_valid && rx_en;
  assign rx_byte  = rx_data;
  assign rx_perr  = (^rx_data) != rx_par;

  assign tx_valid = tx_en;
  assign tx_data  = tx_byte;
  assign tx_par   = ^tx_byte;
  assign tx_fire  = tx_en && tx_ready;

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_par));

  // R6
  one_dir_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_ready, tx_valid}));
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_fire,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_perr,
  input  logic              tx_fire,
  input  logic              irq_ack,
  output logic              rx_en,
  output logic              tx_en,
  output logic [DATA_W-1:0] data_q,
  output logic [ST_BITS-1:0] status,
  output logic              irq,
  output logic              dev_en
);
  seq_st_e state;
  logic    avail, err, busy;
  op_e     op;
  logic    irq_set, rx_done, tx_done;

  assign op      = op_e'(wdata[1:0]);
  assign busy    = (state != S_IDLE);
  assign rx_done = (state == S_RX_WAIT) && rx_fire;
  assign tx_done = (state == S_TX_WAIT) && tx_fire;
  assign irq_set = rx_done || tx_done ||
                   (cmd_wr && (op == OP_CTRL || op == OP_TEST));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      data_q <= '0;
      avail  <= 1'b0;
      err    <= 1'b0;
      dev_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (irq_set)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;

      case (state)
        S_IDLE: begin
          if (data_wr) data_q <= wdata;
          if (cmd_wr && op == OP_READ)  state <= S_RX_WAIT;
          if (cmd_wr && op == OP_WRITE) state <= S_TX_WAIT;
        end
        S_RX_WAIT: begin
          if (rx_fire) begin
            data_q <= rx_byte;
            avail  <= 1'b1;
            state  <= S_RX_HOLD;
            if (rx_perr) err <= 1'b1;
          end
        end
        S_RX_HOLD: begin
          if (data_rd) begin
            avail <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: begin
          if (tx_fire) state <= S_IDLE;
        end
      endcase

      if (cmd_wr && op == OP_CTRL) begin
        dev_en <= wdata[CTRL_EN_BIT];
        err    <= 1'b0;
      end
      if (cmd_wr && busy && (op == OP_READ || op == OP_WRITE)) err <= 1'b1;
    end
  end

  assign rx_en = (state == S_RX_WAIT);
  assign tx_en = (state == S_TX_WAIT);

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = busy;
    status[ST_READY] = !busy;
    status[ST_AVAIL] = avail;
    status[ST_ERR]   = err;
    status[ST_EN]    = dev_en;
    status[ST_IRQ]   = irq;
  end

  // R7
  avail_clear_chk: assert property (@(posedge clk) disable iff (rst)
    data_rd && state == S_RX_HOLD |=> !avail && !busy);

  // R11
  irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !irq_set |=> !irq);

  // R10
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && busy && wdata[1] |=> err);

  // R6
  avail_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(avail) |-> irq && busy);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq,
  input  logic              irq_ack,
  output logic              dev_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_par
);
  logic data_wr, data_rd, stat_rd, cmd_wr;
  logic rx_en, tx_en, rx_fire, rx_perr, tx_fire;
  logic [DATA_W-1:0] data_q, rx_byte;
  logic [ST_BITS-1:0] status;

  pio_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .sel(cpu_sel), .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd),
    .data_wr(data_wr), .data_rd(data_rd), .stat_rd(stat_rd), .cmd_wr(cmd_wr)
  );

  pio_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
    .cmd_wr(cmd_wr), .wdata(cpu_wdata), .rx_fire(rx_fire),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .tx_fire(tx_fire),
    .irq_ack(irq_ack), .rx_en(rx_en), .tx_en(tx_en), .data_q(data_q),
    .status(status), .irq(irq), .dev_en(dev_en)
  );

  pio_link #(.DATA_W(DATA_W)) u_link (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en), .tx_byte(data_q),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_par(rx_par), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_par(tx_par), .rx_fire(rx_fire),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .tx_fire(tx_fire)
  );

  always_comb begin
    cpu_rdata = '0;
    if (data_rd)      cpu_rdata = data_q;
    else if (stat_rd) cpu_rdata = DATA_W'(status);
  end

  // R2
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_sel |-> cpu_rdata == '0);
endmodule

// File: tb/tb_pio_port.sv
`timescale 1ns/1ps
module tb_pio_port;
  logic clk = 0, rst = 1;
  logic cpu_sel = 0, cpu_wr = 0, cpu_rd = 0, irq_ack = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic irq, dev_en, rx_valid = 0, rx_ready, rx_par = 0;
  logic [7:0] rx_data = 0, tx_data;
  logic tx_valid, tx_ready = 0, tx_par;

  localparam logic [7:0] A_DATA = 8'h40, A_STAT = 8'h41, A_CMD = 8'h42;

  int n_chk = 0, n_fail = 0, tx_stall = 0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  pio_port dut (.*);

  task automatic check(input string req, input logic [8:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, d, input logic s = 1'b1);
    @(negedge clk); cpu_sel = s; cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0; cpu_sel = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v, input logic s = 1'b1);
    @(negedge clk); cpu_sel = s; cpu_addr = a; cpu_rd = 1;
    #1 v = cpu_rdata;
    @(negedge clk); cpu_rd = 0; cpu_sel = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic p);
    logic r;
    @(negedge clk); rx_valid = 1; rx_data = d; rx_par = p;
    for (int i = 0; i < 50; i++) begin
      r = rx_ready;
      @(negedge clk);
      if (r) break;
    end
    rx_valid = 0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 50 && !irq; i++) @(negedge clk);
  endtask

  // scoreboard monitor on the peripheral transmit side
  initial begin
    logic [8:0] first, got;
    forever begin
      @(negedge clk);
      if (tx_valid) begin
        first = {tx_data, tx_par};
        for (int i = 0; i < tx_stall; i++) begin
          @(negedge clk);
          check("R9 stall hold", {tx_valid, tx_data}, {1'b1, first[8:1]});
        end
        got = {tx_data, tx_par};
        if (exp_q.size() == 0) check("R9 unexpected tx", got, 9'h1FF);
        else check("R9 tx byte/parity", got, exp_q.pop_front());
        tx_ready = 1;
        @(negedge clk); tx_ready = 0;
        check("R9 valid drops after accept", {8'h0, tx_valid}, 9'h0);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R4 reset state
    bus_rd(A_STAT, v); check("R4 status", {1'b0, v}, 9'h02);
    check("R4 pins", {5'h0, irq, dev_en, rx_ready, tx_valid}, 9'h0);

    // R5 control with enable
    bus_wr(A_CMD, 8'h04);
    check("R5 ctrl dev_en/irq", {7'h0, dev_en, irq}, 9'h3);
    bus_rd(A_STAT, v); check("R3 status after ctrl", {1'b0, v}, 9'h32);
    ack();
    check("R11 ack clears irq", {8'h0, irq}, 9'h0);
    // R5 test command
    bus_wr(A_CMD, 8'h01);
    bus_rd(A_STAT, v); check("R5 test raises irq", {1'b0, v}, 9'h32);
    ack();

    // R2 select low ignored
    bus_wr(A_CMD, 8'h02, 1'b0);
    bus_rd(A_STAT, v); check("R2 cmd ignored", {rx_ready, v}, 9'h012);
    bus_rd(A_STAT, v, 1'b0); check("R2 read zero", {1'b0, v}, 9'h0);

    // R1 address decode
    bus_wr(8'h52, 8'h02);
    bus_rd(A_STAT, v); check("R1 other base ignored", {rx_ready, v}, 9'h012);
    bus_rd(8'h43, v); check("R1 offset3 zero", {1'b0, v}, 9'h0);
    bus_rd(8'h51, v); check("R1 other base read zero", {1'b0, v}, 9'h0);

    // R6 read sequence
    bus_wr(A_CMD, 8'h02);
    bus_rd(A_STAT, v); check("R6 busy", {rx_ready, v}, 9'h111);
    send_rx(8'hA5, 1'b0);
    bus_rd(A_STAT, v); check("R6 captured", {rx_ready, v}, 9'h035);
    bus_rd(A_DATA, v); check("R6 data", {1'b0, v}, 9'h0A5);
    bus_rd(A_STAT, v); check("R7 avail cleared", {1'b0, v}, 9'h32);
    bus_rd(A_DATA, v);
    bus_rd(A_STAT, v); check("R7 second read no avail", {1'b0, v}, 9'h32);
    ack();

    // R8 parity error
    bus_wr(A_CMD, 8'h02);
    send_rx(8'h3C, 1'b1);
    bus_rd(A_STAT, v); check("R8 perr status", {1'b0, v}, 9'h3D);
    bus_rd(A_DATA, v); check("R8 byte kept", {1'b0, v}, 9'h03C);
    ack();
    bus_wr(A_CMD, 8'h02);
    send_rx(8'h11, 1'b0);
    bus_rd(A_DATA, v);
    bus_rd(A_STAT, v); check("R8 error sticky", {1'b0, v}, 9'h3A);
    bus_wr(A_CMD, 8'h04);
    ack();
    bus_rd(A_STAT, v); check("R8 control clears", {1'b0, v}, 9'h12);

    // R9 write with stall
    bus_wr(A_DATA, 8'h5B);
    exp_q.push_back({8'h5B, 1'b1});
    tx_stall = 3;
    bus_wr(A_CMD, 8'h03);
    wait_irq();
    bus_rd(A_STAT, v); check("R9 done status", {1'b0, v}, 9'h32);
    ack();
    bus_wr(A_DATA, 8'h80);
    exp_q.push_back({8'h80, 1'b1});
    tx_stall = 0;
    bus_wr(A_CMD, 8'h03);
    wait_irq();
    bus_rd(A_STAT, v); check("R9 no-stall done", {1'b0, v}, 9'h32);
    check("R9 queue drained", 9'(exp_q.size()), 9'h0);
    ack();

    // R10 commands while busy
    bus_wr(A_CMD, 8'h02);
    bus_wr(A_CMD, 8'h02);
    bus_rd(A_STAT, v); check("R10 read while busy", {1'b0, v}, 9'h19);
    bus_wr(A_CMD, 8'h03);
    check("R10 write ignored", {7'h0, rx_ready, tx_valid}, 9'h2);
    bus_wr(A_DATA, 8'h77);
    send_rx(8'h00, 1'b0);
    bus_rd(A_STAT, v); check("R10 status", {1'b0, v}, 9'h3D);
    bus_rd(A_DATA, v); check("R10 data write ignored", {1'b0, v}, 9'h000);
    ack();
    bus_wr(A_CMD, 8'h04);
    ack();
    bus_rd(A_STAT, v); check("R10 clean", {1'b0, v}, 9'h12);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule